// File: doc/BRIEF.md
# Pin Change and External Interrupt Flag Controller

This block watches twelve general-purpose input pins and one dedicated external interrupt pin and turns their activity into interrupt requests for a processor. The twelve pins form two groups: a low group of eight pins and a high group of four pins. Each pin has its own mask bit. Any rising or falling transition on an unmasked pin sets that group's sticky flag. The external pin has its own flag, and a two-bit sense field selects whether it reacts to a low level, to any change, to a falling edge or to a rising edge.

Software reaches the block through a small register port with four addresses: a mask for each group, a control register, and a flag register. A flag is cleared in one of two ways. Software can write a one to the flag bit, or the processor can pulse an acknowledge strobe that carries the index of the vector it has taken. A request line is raised only when its flag is set, its enable bit is one and the global interrupt enable input is one. The three request lines are ordered by priority: external first, then the low group, then the high group.

Top module: `pcint_flag_ctrl`

## Requirements
- R1: All registers, flags and requests are zero during reset. `rst_n` asserts asynchronously. Internal logic leaves reset on the second rising clock edge after `rst_n` goes high, and pins are treated as low until then.
- R2: Each pin passes through two synchronizing flops. A pin level that is present at clock edge k, and that differs from the level at edge k-1, sets the flag on edge k+2, so the flag is visible after edge k+2.
- R3: A transition on pin n of the low group (n in 0..7) sets flag bit 4 when bit n of the mask at address 0 is one. A transition on pin 8+n sets flag bit 5 when bit n of the mask at address 1 is one. A pin whose mask bit is zero has no effect on either flag.
- R4: `irq_o[1]` equals flag bit 4 AND control bit 4 AND `gie_i`. `irq_o[2]` equals flag bit 5 AND control bit 5 AND `gie_i`. When `gie_i` is zero, all of `irq_o` is zero.
- R5: Writing to address 3 clears every flag whose data bit (6, 5 or 4) is one, and a zero data bit leaves that flag unchanged. A one-cycle `ack_vld_i` strobe with `ack_idx_i` equal to 0, 1 or 2 clears the external, low-group or high-group flag. Index 3 clears nothing.
- R6: If a qualifying event arrives in the same cycle as a clear (by write or by acknowledge), the flag stays set.
- R7: The sense field is control bits 1:0. With 01, any change of the synchronized external pin sets flag bit 6. With 10, only a falling edge sets it. With 11, only a rising edge sets it. `irq_o[0]` equals flag bit 6 AND control bit 6 AND `gie_i`.
- R8: With the sense field at 00, flag bit 6 is held at zero. In that mode `irq_o[0]` equals the inverted synchronized external pin AND control bit 6 AND `gie_i`.
- R9: The register map has four addresses. Address 2 holds enable bits 6 (external), 5 (high group) and 4 (low group) and the sense field in bits 1:0. Reserved bits read as zero: address 1 bits 7:4, address 2 bits 7 and 3:2, and address 3 bits 7 and 3:0. Writes to the flag register never set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 12 | General-purpose pins; 7:0 low group, 11:8 high group |
| ext_pin_i | input | 1 | Dedicated external interrupt pin |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 low mask, 1 high mask, 2 control, 3 flags) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| ack_vld_i | input | 1 | Vector acknowledge strobe |
| ack_idx_i | input | 2 | Acknowledged vector: 0 external, 1 low group, 2 high group |
| irq_o | output | 3 | Requests in priority order: 0 external, 1 low group, 2 high group |

## Verification
Each kind of wrong internal state shows up at the ports:
- A wrong synchronizer or previous-value register gives a flag that is set one cycle early or late, or set with no pin change. This appears on `irq_o` and on the flag read-back within three clock edges of the pin stimulus.
- A stuck or mis-cleared flag keeps a request high after a write-one-to-clear or an acknowledge. This differs from the expected value on the very next edge.
- A wrong sense decode or wrong level-mode hold shows up as a wrong `irq_o[0]` or flag bit 6 during the same external-pin pulse.

The bench compares every output on every clock against a behavioural reference, so the first cycle that differs is reported.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int REG_DW = 8;
  localparam int REG_AW = 2;

  // register addresses
  localparam logic [REG_AW-1:0] ADDR_MASK_LO = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_MASK_HI = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL    = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_FLAG    = 2'd3;

  // request / flag / acknowledge index, also the priority order
  localparam int NSRC    = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_LO  = 1;
  localparam int SRC_HI  = 2;

  // bit positions shared by the control and flag registers
  localparam int BIT_EXT = 6;
  localparam int BIT_HI  = 5;
  localparam int BIT_LO  = 4;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/pcint_rst_sync.sv
module pcint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcint_in_sync.sv
module pcint_in_sync #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= d_i;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur_o = cur_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/pcint_ext_detect.sv
module pcint_ext_detect
  import pcint_pkg::*;
(
  input  logic   cur_i,
  input  logic   prv_i,
  input  sense_e sense_i,
  output logic   evt_o
);
  always_comb begin
    unique case (sense_i)
      SNS_ANY:  evt_o = cur_i ^ prv_i;
      SNS_FALL: evt_o = prv_i & ~cur_i;
      SNS_RISE: evt_o = cur_i & ~prv_i;
      default:  evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcint_flag_cell.sv
module pcint_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_zero_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    if (hold_zero_i)  flag_d = 1'b0;
    else if (set_i)   flag_d = 1'b1;
    else if (clr_i)   flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i && !hold_zero_i) |=> flag_o);
  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero_i |=> !flag_o);
endmodule

// File: rtl/pcint_flag_ctrl.sv
module pcint_flag_ctrl
  import pcint_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LO_W+HI_W-1:0]    pin_i,
  input  logic                    ext_pin_i,
  input  logic                    gie_i,
  input  logic                    wr_en_i,
  input  logic [REG_AW-1:0]       addr_i,
  input  logic [REG_DW-1:0]       wdata_i,
  output logic [REG_DW-1:0]       rdata_o,
  input  logic                    ack_vld_i,
  input  logic [1:0]              ack_idx_i,
  output logic [NSRC-1:0]         irq_o
);
  localparam int PIN_W  = LO_W + HI_W;
  localparam int SYNC_W = PIN_W + 1;
  localparam int EXT_IX = PIN_W;

  logic rst_n_s;

  pcint_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s)
  );

  // ---------------- synchronizers ----------------
  logic [SYNC_W-1:0] cur, prv;

  pcint_in_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i({ext_pin_i, pin_i}),
    .cur_o(cur), .prv_o(prv)
  );

  // ---------------- registers ----------------
  logic [LO_W-1:0] mask_lo_q, mask_lo_d;
  logic [HI_W-1:0] mask_hi_q, mask_hi_d;
  logic [NSRC-1:0] en_q, en_d;
  sense_e          sense_q, sense_d;
  logic            we_lo, we_hi, we_ctrl, we_flag;

  assign we_lo   = wr_en_i && (addr_i == ADDR_MASK_LO);
  assign we_hi   = wr_en_i && (addr_i == ADDR_MASK_HI);
  assign we_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign we_flag = wr_en_i && (addr_i == ADDR_FLAG);

  always_comb begin
    mask_lo_d = mask_lo_q;
    mask_hi_d = mask_hi_q;
    en_d      = en_q;
    sense_d   = sense_q;
    if (we_lo) mask_lo_d = wdata_i[LO_W-1:0];
    if (we_hi) mask_hi_d = wdata_i[HI_W-1:0];
    if (we_ctrl) begin
      en_d[SRC_EXT] = wdata_i[BIT_EXT];
      en_d[SRC_LO]  = wdata_i[BIT_LO];
      en_d[SRC_HI]  = wdata_i[BIT_HI];
      sense_d       = sense_e'(wdata_i[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mask_lo_q <= '0;
      mask_hi_q <= '0;
      en_q      <= '0;
      sense_q   <= SNS_LOW;
    end else begin
      mask_lo_q <= mask_lo_d;
      mask_hi_q <= mask_hi_d;
      en_q      <= en_d;
      sense_q   <= sense_d;
    end
  end

  // ---------------- event detection ----------------
  logic [PIN_W-1:0] change;
  logic [NSRC-1:0]  set_v, clr_v, flag_q;
  logic             ext_evt, level_mode;

  assign change = (cur[PIN_W-1:0] ^ prv[PIN_W-1:0]) & {mask_hi_q, mask_lo_q};
  assign level_mode = (sense_q == SNS_LOW);

  pcint_ext_detect u_ext (
    .cur_i(cur[EXT_IX]), .prv_i(prv[EXT_IX]), .sense_i(sense_q), .evt_o(ext_evt)
  );

  assign set_v[SRC_EXT] = ext_evt;
  assign set_v[SRC_LO]  = |change[LO_W-1:0];
  assign set_v[SRC_HI]  = |change[PIN_W-1:LO_W];

  // write-one-to-clear data bit for each source
  logic [NSRC-1:0] w1c_bits;
  assign w1c_bits[SRC_EXT] = wdata_i[BIT_EXT];
  assign w1c_bits[SRC_LO]  = wdata_i[BIT_LO];
  assign w1c_bits[SRC_HI]  = wdata_i[BIT_HI];

  // ---------------- flags ----------------
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic hold_zero;
    assign clr_v[i] = (we_flag && w1c_bits[i]) ||
                      (ack_vld_i && (ack_idx_i == 2'(i)));
    if (i == SRC_EXT) begin : g_ext_hold
      assign hold_zero = level_mode;
    end else begin : g_no_hold
      assign hold_zero = 1'b0;
    end
    pcint_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n_s), .set_i(set_v[i]), .clr_i(clr_v[i]),
      .hold_zero_i(hold_zero), .flag_o(flag_q[i])
    );
  end

  // ---------------- requests ----------------
  always_comb begin
    irq_o[SRC_LO] = gie_i & en_q[SRC_LO] & flag_q[SRC_LO];
    irq_o[SRC_HI] = gie_i & en_q[SRC_HI] & flag_q[SRC_HI];
    if (level_mode) irq_o[SRC_EXT] = gie_i & en_q[SRC_EXT] & ~cur[EXT_IX];
    else            irq_o[SRC_EXT] = gie_i & en_q[SRC_EXT] & flag_q[SRC_EXT];
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_MASK_LO: rdata_o[LO_W-1:0] = mask_lo_q;
      ADDR_MASK_HI: rdata_o[HI_W-1:0] = mask_hi_q;
      ADDR_CTRL: begin
        rdata_o[BIT_EXT] = en_q[SRC_EXT];
        rdata_o[BIT_HI]  = en_q[SRC_HI];
        rdata_o[BIT_LO]  = en_q[SRC_LO];
        rdata_o[1:0]     = sense_q;
      end
      default: begin
        rdata_o[BIT_EXT] = flag_q[SRC_EXT];
        rdata_o[BIT_HI]  = flag_q[SRC_HI];
        rdata_o[BIT_LO]  = flag_q[SRC_LO];
      end
    endcase
  end

  // ---------------- assertions ----------------
  p_gie_gates_all_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !gie_i |-> (irq_o == '0));
  p_ack_hi_clears_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_vld_i && ack_idx_i == 2'(SRC_HI) && !set_v[SRC_HI]) |=> !flag_q[SRC_HI]);
  p_rise_sets_ext_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sense_q == SNS_RISE && cur[EXT_IX] && !prv[EXT_IX]) |=> flag_q[SRC_EXT]);
  p_masked_pin_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mask_lo_q == '0 && !flag_q[SRC_LO]) |=> !flag_q[SRC_LO]);
endmodule

// File: tb/pcint_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcint_flag_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] pin_i;
  logic        ext_pin_i, gie_i, wr_en_i, ack_vld_i;
  logic [1:0]  addr_i, ack_idx_i;
  logic [7:0]  wdata_i, rdata_o;
  logic [2:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcint_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ext_pin_i(ext_pin_i),
    .gie_i(gie_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .ack_vld_i(ack_vld_i), .ack_idx_i(ack_idx_i), .irq_o(irq_o)
  );

  // ---------------- behavioural reference ----------------
  logic [12:0] m_s1, m_s2, m_p, chg;
  logic [7:0]  m_mask0, m_ctrl;
  logic [3:0]  m_mask1;
  logic [2:0]  m_flag, st, cl, nf;
  int          m_rcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_p = '0; m_mask0 = '0; m_mask1 = '0;
      m_ctrl = '0; m_flag = '0; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt = m_rcnt + 1;
    end else begin
      chg = (m_s2 ^ m_p) & {1'b0, m_mask1, m_mask0};
      st[1] = |chg[7:0];
      st[2] = |chg[11:8];
      case (m_ctrl[1:0])
        2'd0:    st[0] = 1'b0;
        2'd1:    st[0] = m_s2[12] ^ m_p[12];
        2'd2:    st[0] = m_p[12] & ~m_s2[12];
        default: st[0] = m_s2[12] & ~m_p[12];
      endcase
      cl = '0;
      if (wr_en_i && addr_i == 2'd3) cl = {wdata_i[5], wdata_i[4], wdata_i[6]};
      if (ack_vld_i && ack_idx_i != 2'd3) cl[ack_idx_i] = 1'b1;
      nf = st | (m_flag & ~cl);
      if (m_ctrl[1:0] == 2'd0) nf[0] = 1'b0;
      if (wr_en_i) begin
        case (addr_i)
          2'd0: m_mask0 = wdata_i;
          2'd1: m_mask1 = wdata_i[3:0];
          2'd2: m_ctrl  = wdata_i & 8'h73;
          default: ;
        endcase
      end
      m_flag = nf;
      m_p  = m_s2;
      m_s2 = m_s1;
      m_s1 = {ext_pin_i, pin_i};
    end
  end

  function automatic logic [2:0] exp_irq();
    logic [2:0] e;
    e[0] = gie_i & m_ctrl[6] & ((m_ctrl[1:0] == 2'd0) ? ~m_s2[12] : m_flag[0]);
    e[1] = gie_i & m_ctrl[4] & m_flag[1];
    e[2] = gie_i & m_ctrl[5] & m_flag[2];
    return e;
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return m_mask0;
      2'd1:    return {4'b0, m_mask1};
      2'd2:    return m_ctrl;
      default: return {1'b0, m_flag[0], m_flag[2], m_flag[1], 4'b0};
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      logic [2:0] ei;
      ei = exp_irq();
      check("R4 irq_lo", {7'b0, irq_o[1]}, {7'b0, ei[1]});
      check("R4 irq_hi", {7'b0, irq_o[2]}, {7'b0, ei[2]});
      if (m_ctrl[1:0] == 2'd0) check("R8 irq_ext", {7'b0, irq_o[0]}, {7'b0, ei[0]});
      else                     check("R7 irq_ext", {7'b0, irq_o[0]}, {7'b0, ei[0]});
      if (addr_i == 2'd3) check("R3 flag read", rdata_o, exp_rd(addr_i));
      else                check("R9 reg read", rdata_o, exp_rd(addr_i));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic ack(logic [1:0] idx);
    @(negedge clk); ack_vld_i = 1; ack_idx_i = idx;
    @(negedge clk); ack_vld_i = 0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr_i = a;
    @(posedge clk); #2;
    check(tag, rdata_o, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- directed + random sequence ----------------
  initial begin
    rst_n = 0; pin_i = '0; ext_pin_i = 1; gie_i = 0; wr_en_i = 0;
    addr_i = 0; wdata_i = 0; ack_vld_i = 0; ack_idx_i = 0;
    idle(5);
    rst_n = 1;
    idle(4);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 8'h00, "R1 reset reg");
    check("R1 reset irq", {5'b0, irq_o}, 8'h00);

    // R9 reserved bits
    wr(2'd1, 8'hFF); rd_chk(2'd1, 8'h0F, "R9 hi mask reserved");
    wr(2'd2, 8'hFF); rd_chk(2'd2, 8'h73, "R9 ctrl reserved");
    wr(2'd3, 8'hFF); rd_chk(2'd3, 8'h00, "R9 flag write no set");

    // R2 latency: low group, pin 0 only
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h13);           // lo enable, rising sense
    gie_i = 1;
    idle(4);
    @(negedge clk); pin_i[0] = 1;
    @(posedge clk); #2; check("R2 edge k", {7'b0, irq_o[1]}, 8'h00);
    @(posedge clk); #2; check("R2 edge k+1", {7'b0, irq_o[1]}, 8'h00);
    @(posedge clk); #2; check("R2 edge k+2", {7'b0, irq_o[1]}, 8'h01);
    rd_chk(2'd3, 8'h10, "R3 lo flag set");

    // R5 write zero no effect, write one clears
    wr(2'd3, 8'h00); rd_chk(2'd3, 8'h10, "R5 write zero keeps");
    wr(2'd3, 8'h10); rd_chk(2'd3, 8'h00, "R5 w1c clears");

    // R3 masked-out pin
    @(negedge clk); pin_i[1] = 1; idle(5);
    rd_chk(2'd3, 8'h00, "R3 masked pin ignored");

    // R3/R5 high group + acknowledge
    wr(2'd1, 8'h04); wr(2'd2, 8'h33);
    @(negedge clk); pin_i[10] = 1; idle(4);
    rd_chk(2'd3, 8'h20, "R3 hi flag set");
    ack(2'd3); rd_chk(2'd3, 8'h20, "R5 ack idx3 no clear");
    ack(2'd2); rd_chk(2'd3, 8'h00, "R5 ack hi clears");

    // R6 event coincides with clear
    @(negedge clk); pin_i[0] = 0;
    @(negedge clk); pin_i[0] = 1;
    @(negedge clk);                 // first change sets flag at this edge
    wr_en_i = 1; addr_i = 2'd3; wdata_i = 8'h10;
    @(negedge clk); wr_en_i = 0;
    rd_chk(2'd3, 8'h10, "R6 set beats clear");
    ack(2'd1); idle(3);

    // R7 external edge modes
    ext_pin_i = 0; wr(2'd2, 8'h43); idle(4); wr(2'd3, 8'h40);
    @(negedge clk); ext_pin_i = 1; idle(4);
    rd_chk(2'd3, 8'h40, "R7 rising sets");
    ack(2'd0);
    @(negedge clk); ext_pin_i = 0; idle(4);
    rd_chk(2'd3, 8'h00, "R7 falling ignored in rise mode");
    wr(2'd2, 8'h42);
    @(negedge clk); ext_pin_i = 1; idle(4);
    rd_chk(2'd3, 8'h00, "R7 rising ignored in fall mode");
    @(negedge clk); ext_pin_i = 0; idle(4);
    rd_chk(2'd3, 8'h40, "R7 falling sets");

    // R8 level mode
    wr(2'd2, 8'h40); idle(2);
    rd_chk(2'd3, 8'h00, "R8 flag held zero");
    check("R8 low level request", {7'b0, irq_o[0]}, 8'h01);
    @(negedge clk); ext_pin_i = 1; idle(3);
    check("R8 high level no request", {7'b0, irq_o[0]}, 8'h00);

    // R4 gie gating
    @(negedge clk); pin_i[0] = 0; gie_i = 0; idle(4);
    check("R4 gie low", {5'b0, irq_o}, 8'h00);

    // random traffic, checked every clock by the reference
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      pin_i     = 12'($urandom);
      ext_pin_i = 1'($urandom);
      gie_i     = ($urandom % 4) != 0;
      wr_en_i   = ($urandom % 5) == 0;
      addr_i    = 2'($urandom);
      wdata_i   = 8'($urandom);
      ack_vld_i = ($urandom % 6) == 0;
      ack_idx_i = 2'($urandom);
    end
    @(negedge clk); wr_en_i = 0; ack_vld_i = 0;
    idle(4);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule